// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives a four-digit common-cathode LED display from one shared seven-segment bus. It receives two four-digit BCD words: a running count and a frozen copy of that count. A display-source input picks which of the two appears. The block lights one digit at a time, in a fixed rotation. It only needs the system clock. A free-running prescaler inside the block divides that clock down to the digit step rate.

With the default divide ratio and a 250 MHz system clock, the scan steps at 1 kHz. That rate sits well inside the usual 100 Hz to 5 kHz band for flicker-free multiplexing.

The source choice is taken only when the scan moves to the next digit, so one digit period never mixes live and frozen data. Segments are dark for the first clock of every digit period. This keeps the pattern of the previous digit from flashing on the newly enabled one.

Top module: `seg_scan_top`

## Requirements
- R1: While the sampled source flag is 1, the displayed digits come from `live_bcd`. While it is 0, they come from `held_bcd`.
- R2: Exactly one bit of `dig_en_o` is high in every cycle, including reset.
- R3: The active digit steps in the order 0, 1, 2, 3, 0. Digit i shows bits [4i+3:4i] of the selected word, and `dig_en_o[i]` is its enable.
- R4: Each digit stays enabled for exactly PRESCALE system clocks, counted from reset release.
- R5: `seg_o` bit 0 is segment a and bit 6 is segment g, active high. BCD 0 to 9 give the hex codes 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F. Codes 10 to 15 give 00.
- R6: `seg_o` is 00 during the first system clock of every digit period.
- R7: `show_live` is sampled only on the clock edge that moves the scan to the next digit. A change at any other time has no effect on the segments until that edge.
- R8: While `rst_n` is low, and in the first cycle after it rises: digit 0 is enabled, the segments are dark, and the source flag is 0 (frozen word).
- R9: Within a digit period, after its first clock, the segments follow the selected BCD input in the same cycle, without extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| live_bcd | input | 16 | Running count, four BCD digits, digit 0 in the low nibble |
| held_bcd | input | 16 | Frozen count, same layout |
| show_live | input | 1 | Display source: 1 shows the running count, 0 shows the frozen count |
| seg_o | output | 7 | Segment drive a to g, active high |
| dig_en_o | output | 4 | One-hot digit enable |

## Verification
A wrong step counter or digit index appears on `dig_en_o` within one digit period. It shows up as a period of the wrong length, a skipped or repeated digit, or more than one digit enabled. A stuck or badly sampled source flag appears within one digit period: the bench model tracks when `show_live` was sampled, so segments taken from the wrong word, or switched in the middle of a digit, differ from the expected values in that same cycle. A missing blank cycle or a wrong decode entry is visible on `seg_o` in the cycle it happens. The stimulus sweeps every code on every digit, so each decode entry is checked.

// File: rtl/seg_scan_pkg.sv
`timescale 1ns/1ps
package seg_scan_pkg;
   localparam int SEG_W = 7;
   localparam int BCD_W = 4;

   typedef logic [SEG_W-1:0] seg_t;

   // Segment bit 0 = a ... bit 6 = g, active high; non-decimal codes stay dark.
   function automatic seg_t bcd_to_seg(input logic [BCD_W-1:0] code);
      seg_t s;
      case (code)
         4'd0:    s = 7'h3F;
         4'd1:    s = 7'h06;
         4'd2:    s = 7'h5B;
         4'd3:    s = 7'h4F;
         4'd4:    s = 7'h66;
         4'd5:    s = 7'h6D;
         4'd6:    s = 7'h7D;
         4'd7:    s = 7'h07;
         4'd8:    s = 7'h7F;
         4'd9:    s = 7'h6F;
         default: s = 7'h00;
      endcase
      return s;
   endfunction
endpackage

// File: rtl/seg_scan_prescaler.sv
`timescale 1ns/1ps
module seg_scan_prescaler #(
   parameter int PRESCALE = 250000
) (
   input  logic clk,
   input  logic rst_n,
   output logic step_o
);
   localparam int CNT_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(PRESCALE - 1);
   localparam bit IS_POW2 = (PRESCALE & (PRESCALE - 1)) == 0;

   generate
      if (PRESCALE < 2) begin : g_bad_ratio
         $error("seg_scan_prescaler: PRESCALE must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;

   generate
      if (IS_POW2) begin : g_wrap
         // Power-of-two ratio: the counter wraps by itself, no compare-clear.
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + 1'b1;
         end
         assign step_o = &cnt_q;
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              cnt_q <= '0;
            else if (cnt_q == LAST)  cnt_q <= '0;
            else                     cnt_q <= cnt_q + 1'b1;
         end
         assign step_o = (cnt_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/seg_scan_sequencer.sv
`timescale 1ns/1ps
module seg_scan_sequencer #(
   parameter int DIGITS = 4,
   localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             sel_live_i,
   output logic [IDX_W-1:0] idx_o,
   output logic             src_live_o,
   output logic             blank_o
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DIGITS - 1);

   generate
      if (DIGITS < 2) begin : g_bad_digits
         $error("seg_scan_sequencer: DIGITS must be at least 2");
      end
   endgenerate

   logic [IDX_W-1:0] idx_q;
   logic             src_q;
   logic             blank_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         src_q   <= 1'b0;
         blank_q <= 1'b1;
      end else if (step_i) begin
         idx_q   <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
         src_q   <= sel_live_i;
         blank_q <= 1'b1;
      end else begin
         blank_q <= 1'b0;
      end
   end

   assign idx_o      = idx_q;
   assign src_live_o = src_q;
   assign blank_o    = blank_q;
endmodule

// File: rtl/seg_scan_decoder.sv
`timescale 1ns/1ps
module seg_scan_decoder
   import seg_scan_pkg::*;
(
   input  logic [BCD_W-1:0] code_i,
   input  logic             blank_i,
   output seg_t             seg_o
);
   assign seg_o = blank_i ? '0 : bcd_to_seg(code_i);
endmodule

// File: rtl/seg_scan_top.sv
`timescale 1ns/1ps
module seg_scan_top
   import seg_scan_pkg::*;
#(
   parameter int DIGITS   = 4,
   parameter int PRESCALE = 250000,
   localparam int DATA_W  = DIGITS * BCD_W,
   localparam int IDX_W   = (DIGITS > 1) ? $clog2(DIGITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] live_bcd,
   input  logic [DATA_W-1:0] held_bcd,
   input  logic              show_live,
   output logic [SEG_W-1:0]  seg_o,
   output logic [DIGITS-1:0] dig_en_o
);
   logic             step;
   logic [IDX_W-1:0] idx;
   logic             src_live;
   logic             blank;
   logic [DATA_W-1:0] chosen;
   logic [BCD_W-1:0]  nibble;

   seg_scan_prescaler #(.PRESCALE(PRESCALE)) u_pre (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_o (step)
   );

   seg_scan_sequencer #(.DIGITS(DIGITS)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step),
      .sel_live_i (show_live),
      .idx_o      (idx),
      .src_live_o (src_live),
      .blank_o    (blank)
   );

   assign chosen = src_live ? live_bcd : held_bcd;
   assign nibble = chosen[idx*BCD_W +: BCD_W];

   seg_scan_decoder u_dec (
      .code_i  (nibble),
      .blank_i (blank),
      .seg_o   (seg_o)
   );

   generate
      for (genvar g = 0; g < DIGITS; g++) begin : g_dig
         assign dig_en_o[g] = (idx == IDX_W'(g));
      end
   endgenerate
endmodule

// File: rtl/seg_scan_chk.sv
`timescale 1ns/1ps
module seg_scan_chk #(
   parameter int DIGITS   = 4,
   parameter int PRESCALE = 250000,
   localparam int DATA_W  = DIGITS * 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [DATA_W-1:0] live_bcd,
   input logic [DATA_W-1:0] held_bcd,
   input logic              show_live,
   input logic [6:0]        seg_o,
   input logic [DIGITS-1:0] dig_en_o
);
   logic [DIGITS-1:0] prev_q;
   int unsigned       dwell_q;
   logic              moved;

   assign moved = (dig_en_o != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= DIGITS'(1);
         dwell_q <= 0;
      end else begin
         prev_q  <= dig_en_o;
         dwell_q <= moved ? 1 : dwell_q + 1;
      end
   end

   AST_DIGIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dig_en_o) == 1); // R2

   AST_DIGIT_ROTATE: assert property (@(posedge clk) disable iff (!rst_n)
      moved |-> dig_en_o == {prev_q[DIGITS-2:0], prev_q[DIGITS-1]}); // R3

   AST_DWELL_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      moved |-> dwell_q == PRESCALE); // R4

   AST_DWELL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      dwell_q <= PRESCALE); // R4

   AST_BLANK_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      moved |-> seg_o == 7'h00); // R6

   AST_SOURCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!moved && $stable(live_bcd) && $stable(held_bcd) && $past(seg_o) != 7'h00)
      |-> $stable(seg_o)); // R7
endmodule

bind seg_scan_top seg_scan_chk #(.DIGITS(DIGITS), .PRESCALE(PRESCALE)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .live_bcd  (live_bcd),
   .held_bcd  (held_bcd),
   .show_live (show_live),
   .seg_o     (seg_o),
   .dig_en_o  (dig_en_o)
);

// File: tb/tb_seg_scan_top.sv
`timescale 1ns/1ps
module tb_seg_scan_top;
   localparam int P = 6;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] live_bcd, held_bcd;
   logic        show_live;
   logic [6:0]  seg_o;
   logic [3:0]  dig_en_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 0;

   int m_cyc;
   bit m_src;

   always #2 clk = ~clk;

   seg_scan_top #(.DIGITS(4), .PRESCALE(P)) dut (
      .clk(clk), .rst_n(rst_n), .live_bcd(live_bcd), .held_bcd(held_bcd),
      .show_live(show_live), .seg_o(seg_o), .dig_en_o(dig_en_o)
   );

   function automatic logic [6:0] exp_seg(input logic [3:0] v);
      case (v)
         0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
         4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
         8: return 7'h7F; 9: return 7'h6F;
         default: return 7'h00;
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // Reference timing: cycle count since release, source flag taken at digit steps (R7).
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cyc <= 0;
         m_src <= 1'b0;
      end else begin
         if (m_cyc % P == P - 1) m_src <= show_live;
         m_cyc <= m_cyc + 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int          idx;
         logic [15:0] word;
         logic [6:0]  es;
         idx  = (m_cyc / P) % 4;
         word = m_src ? live_bcd : held_bcd;                 // R1
         es   = (m_cyc % P == 0) ? 7'h00                     // R6
                                 : exp_seg(word[idx*4 +: 4]); // R5 R9
         chk(dig_en_o == 4'(1 << idx), "R3/R4 digit enable", dig_en_o, 1 << idx);
         chk(seg_o == es, "R1/R5/R6/R7 segments", seg_o, es);
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL R4 watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED));
      rst_n = 1'b0; live_bcd = 16'h1111; held_bcd = 16'h2222; show_live = 1'b0;
      repeat (3) @(negedge clk);
      chk(dig_en_o == 4'b0001, "R8 reset digit", dig_en_o, 1);
      chk(seg_o == 7'h00, "R8 reset segments", seg_o, 0);
      show_live = 1'b1; live_bcd = 16'h8888;
      repeat (2) @(negedge clk);
      chk(dig_en_o == 4'b0001, "R8 reset ignores inputs", dig_en_o, 1);
      chk(seg_o == 7'h00, "R8 reset stays dark", seg_o, 0);

      // Release; first digit period shows the frozen word (R8).
      held_bcd = 16'h0123; live_bcd = 16'h9876; show_live = 1'b1;
      @(posedge clk); #1 rst_n = 1'b1;
      step(4 * P * 3);
      show_live = 1'b0;                 // R1: back to frozen word
      step(4 * P * 2);
      live_bcd = 16'hFA5C; show_live = 1'b1; // R5: codes 10..15 dark
      step(4 * P * 2);
      // Mid-digit toggles must wait for the next step (R7).
      for (int k = 0; k < 8; k++) begin
         step(P / 2);
         show_live = ~show_live;
      end
      // Sweep every code on every digit (R5).
      for (int n = 0; n < 16; n++) begin
         live_bcd  = {4{4'(n)}};
         held_bcd  = {4{4'(15 - n)}};
         show_live = n[0];
         step(4 * P);
      end
      // Random mix (R1 R7 R9).
      for (int c = 0; c < 4000; c++) begin
         if ($urandom % 16 == 0) live_bcd = 16'($urandom);
         if ($urandom % 16 == 0) held_bcd = 16'($urandom);
         if ($urandom % 8 == 0)  show_live = ~show_live;
         step(1);
      end
      @(negedge clk);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule